// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block models a single-clock synchronous SRAM with a registered input stage, a registered output stage and an internal burst sequencer. Every synchronous pin is sampled on the rising clock edge. An access starts when one of two address strobes loads a new address: a processor strobe that always begins a read, or a controller strobe that can begin a read or a write. Later beats of a burst come from a two-bit counter. The counter steps when the advance input is asserted and holds when it is not, so the access is repeated.

The two low address bits of a beat are built from the loaded low bits and the counter. A run-time order pin selects linear order (wrap modulo four) or interleaved order (exclusive-or). Writes are byte-granular: a byte-write enable qualifies one enable per byte, and a global write stores the whole word. Read data reaches the outputs two clock edges after the address is captured.

A pipelined enable stage keeps the data drivers on for one extra cycle after a deselect, so that banks can share a bus without a wait state. The output enable pin gates the driver indication without passing through a clock.

Top module: `psram_core`

## Requirements
- R1: After reset, and until a read has been issued, `q_en_o` is 0.
- R2: A selected read whose pins are present at rising edge t puts the word on `q_o` with `q_en_o`=1 after edge t+1. A burst returns one word per clock after that.
- R3: Asserting `pstb_n_i`=0 while `cs1_n_i`=0 loads `addr_i` and starts a read, even if write controls are asserted. If both strobes are active, the processor strobe wins.
- R4: `pstb_n_i`=0 while `cs1_n_i`=1 is ignored. With `cstb_n_i`=1 and `adv_n_i`=1, the previous address is accessed again.
- R5: `cstb_n_i`=0 loads `addr_i`. The chip is selected when `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0. A selected load with `gw_n_i`=0 writes all bytes of `wdata_i`, whatever `bw_n_i` and `bwen_n_i` hold.
- R6: With `order_i`=0, beat k of a burst uses low address bits (start+k) mod 4. The upper bits stay fixed.
- R7: With `order_i`=1, beat k uses low address bits start XOR k.
- R8: In a cycle with no load while the chip is active, `adv_n_i`=0 steps the burst counter and `adv_n_i`=1 repeats the current address. This applies to reads and writes.
- R9: A load with the chip deselected ends the access. If the last access was a read, `q_en_o` stays 1 with `q_o` unchanged for one more cycle, then goes to 0.
- R10: `oe_n_i`=1 forces `q_en_o` to 0 at once, without a clock edge.
- R11: With `gw_n_i`=1 and `bwen_n_i`=0, only bytes whose `bw_n_i` bit is 0 are written. Byte i is `wdata_i[8i+7:8i]`. With both `gw_n_i` and `bwen_n_i` at 1, the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | NUM_BYTES*BYTE_W | Write data |
| cs1_n_i | input | 1 | Chip select, active low, also qualifies the processor strobe |
| cs2_i | input | 1 | Depth-expansion select, active high |
| cs3_n_i | input | 1 | Depth-expansion select, active low |
| pstb_n_i | input | 1 | Processor address strobe, active low |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| bw_n_i | input | NUM_BYTES | Per-byte write enables, active low |
| bwen_n_i | input | 1 | Byte-write qualifier, active low |
| gw_n_i | input | 1 | Global write, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| q_o | output | NUM_BYTES*BYTE_W | Registered read data |
| q_en_o | output | 1 | Data drivers on |

## Verification
Four-beat read bursts start from a low address of 1 under both orders. The resulting sequences 1,2,3,0 and 1,0,3,2 show that the order pin is honoured and that the linear order wraps. Writes are issued three ways: as global writes, as masked byte writes with a mixed enable pattern, and with write controls present under the processor strobe. Reads afterwards show which bytes changed, so a swapped lane or a missing override is caught. Suspended beats, an ignored processor strobe and a deselect after a read check that the address is held and that the drivers stay on for one extra cycle before turning off.

// File: rtl/psram_pkg.sv
package psram_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2
   } acc_e;

   // low two address bits of a burst beat
   function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      return ilv ? (start ^ cnt) : (start + cnt);
   endfunction
endpackage

// File: rtl/psram_burst_seq.sv
module psram_burst_seq #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              step_i,
   input  logic              ilv_i,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [1:0]        cnt_o
);
   import psram_pkg::*;

   logic [ADDR_W-1:0] base_q, base_now;
   logic [1:0]        cnt_q, cnt_now;

   always_comb begin
      if (load_i) begin
         base_now = load_addr_i;
         cnt_now  = 2'd0;
      end else begin
         base_now = base_q;
         cnt_now  = cnt_q + {1'b0, step_i};
      end
   end

   assign acc_addr_o = {base_now[ADDR_W-1:2], beat_lsb(base_now[1:0], cnt_now, ilv_i)};
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else begin
         base_q <= base_now;
         cnt_q  <= cnt_now;
      end
   end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
   parameter int ADDR_W    = 6,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input  logic                        clk,
   input  logic [NUM_BYTES-1:0]        we_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
   output logic [NUM_BYTES*BYTE_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we_i[g]) lane_mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
      end

      assign rdata_o[g*BYTE_W +: BYTE_W] = lane_mem[addr_i];
   end
endmodule

// File: rtl/psram_out_stage.sv
module psram_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              idle_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              oe_n_i,
   output logic [DATA_W-1:0] q_o,
   output logic              drv_o,
   output logic              q_en_o
);
   logic [DATA_W-1:0] data_q;
   logic              rd_q, ds_q, prv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         rd_q   <= 1'b0;
         ds_q   <= 1'b0;
         prv_q  <= 1'b0;
      end else begin
         if (rd_i) data_q <= rdata_i;
         rd_q  <= rd_i;
         ds_q  <= idle_i;
         prv_q <= rd_q;
      end
   end

   // second stage keeps drivers on across the first deselected cycle
   assign drv_o  = rd_q | (ds_q & prv_q);
   assign q_en_o = drv_o & ~oe_n_i;
   assign q_o    = data_q;
endmodule

// File: rtl/psram_core.sv
module psram_core #(
   parameter int ADDR_W    = 6,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
   input  logic                        cs1_n_i,
   input  logic                        cs2_i,
   input  logic                        cs3_n_i,
   input  logic                        pstb_n_i,
   input  logic                        cstb_n_i,
   input  logic                        adv_n_i,
   input  logic [NUM_BYTES-1:0]        bw_n_i,
   input  logic                        bwen_n_i,
   input  logic                        gw_n_i,
   input  logic                        order_i,
   input  logic                        oe_n_i,
   output logic [NUM_BYTES*BYTE_W-1:0] q_o,
   output logic                        q_en_o
);
   import psram_pkg::*;

   localparam int DATA_W = NUM_BYTES * BYTE_W;

   initial begin : p_param_chk
      if (ADDR_W < 2)    $fatal(1, "ADDR_W must cover the two burst bits");
      if (NUM_BYTES < 1) $fatal(1, "NUM_BYTES must be at least 1");
      if (BYTE_W < 1)    $fatal(1, "BYTE_W must be at least 1");
   end

   // input register stage
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    wdata_q;
   logic                 cs1_n_q, cs2_q, cs3_n_q;
   logic                 pstb_n_q, cstb_n_q, adv_n_q;
   logic [NUM_BYTES-1:0] bw_n_q;
   logic                 bwen_n_q, gw_n_q, order_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         cs1_n_q  <= 1'b1;
         cs2_q    <= 1'b0;
         cs3_n_q  <= 1'b1;
         pstb_n_q <= 1'b1;
         cstb_n_q <= 1'b1;
         adv_n_q  <= 1'b1;
         bw_n_q   <= '1;
         bwen_n_q <= 1'b1;
         gw_n_q   <= 1'b1;
         order_q  <= 1'b0;
      end else begin
         addr_q   <= addr_i;
         wdata_q  <= wdata_i;
         cs1_n_q  <= cs1_n_i;
         cs2_q    <= cs2_i;
         cs3_n_q  <= cs3_n_i;
         pstb_n_q <= pstb_n_i;
         cstb_n_q <= cstb_n_i;
         adv_n_q  <= adv_n_i;
         bw_n_q   <= bw_n_i;
         bwen_n_q <= bwen_n_i;
         gw_n_q   <= gw_n_i;
         order_q  <= order_i;
      end
   end

   // access decode
   logic                 sel, pload, load, active_q, active_now, step;
   logic [NUM_BYTES-1:0] mask_raw, we;
   logic [ADDR_W-1:0]    acc_addr;
   logic [DATA_W-1:0]    rdata;
   logic [1:0]           cnt;
   logic                 drv;
   acc_e                 acc;

   assign sel        = ~cs1_n_q & cs2_q & ~cs3_n_q;
   assign pload      = ~pstb_n_q & ~cs1_n_q;
   assign load       = pload | ~cstb_n_q;
   assign active_now = load ? sel : active_q;
   assign step       = ~load & active_q & ~adv_n_q;

   always_comb begin
      if (!gw_n_q)        mask_raw = '1;
      else if (!bwen_n_q) mask_raw = ~bw_n_q;
      else                mask_raw = '0;
   end

   always_comb begin
      if (!active_now)                 acc = ACC_NONE;
      else if (!pload && |mask_raw)    acc = ACC_WR;
      else                             acc = ACC_RD;
   end

   assign we = (acc == ACC_WR) ? mask_raw : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_now;
   end

   psram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_addr_i(addr_q),
      .step_i     (step),
      .ilv_i      (order_q),
      .acc_addr_o (acc_addr),
      .cnt_o      (cnt)
   );

   psram_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_mem (
      .clk    (clk),
      .we_i   (we),
      .addr_i (acc_addr),
      .wdata_i(wdata_q),
      .rdata_o(rdata)
   );

   psram_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_i   (acc == ACC_RD),
      .idle_i (acc == ACC_NONE),
      .rdata_i(rdata),
      .oe_n_i (oe_n_i),
      .q_o    (q_o),
      .drv_o  (drv),
      .q_en_o (q_en_o)
   );
endmodule

// File: rtl/psram_core_chk.sv
module psram_core_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        acc_i,
   input logic              step_i,
   input logic [1:0]        cnt_i,
   input logic              drv_i,
   input logic [DATA_W-1:0] q_o,
   input logic              q_en_o,
   input logic              oe_n_i
);
   // R2: a read access turns the drivers on at the next edge
   a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == 2'd1) |=> drv_i);

   // R5: a write access leaves the drivers off
   a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == 2'd2) |=> !drv_i);

   // R8: an advance step moves the burst counter by one
   a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (cnt_i == 2'($past(cnt_i) + 2'd1)));

   // R9: the first deselected cycle after a read holds data and drivers
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_i) == 2'd1 && acc_i == 2'd0) |=> (drv_i && $stable(q_o)));

   // R9: a second deselected cycle turns the drivers off
   a_r9_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_i) == 2'd0 && acc_i == 2'd0) |=> !drv_i);

   // R10: output enable high forces the drivers off immediately
   always_comb begin
      if (rst_n && oe_n_i) a_r10_oe: assert (!q_en_o);
   end
endmodule

bind psram_core psram_core_chk #(.DATA_W(NUM_BYTES*BYTE_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .acc_i (acc),
   .step_i(step),
   .cnt_i (cnt),
   .drv_i (drv),
   .q_o   (q_o),
   .q_en_o(q_en_o),
   .oe_n_i(oe_n_i)
);

// File: tb/tb_psram_core.sv
module tb_psram_core;
   localparam int AW = 6;
   localparam int NB = 4;
   localparam int DW = NB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic          cs1_n_i = 1'b1, cs2_i = 1'b1, cs3_n_i = 1'b0;
   logic          pstb_n_i = 1'b1, cstb_n_i = 1'b1, adv_n_i = 1'b1;
   logic [NB-1:0] bw_n_i = '1;
   logic          bwen_n_i = 1'b1, gw_n_i = 1'b1, order_i = 1'b0, oe_n_i = 1'b0;
   logic [DW-1:0] q_o;
   logic          q_en_o;

   psram_core #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
      .cs1_n_i(cs1_n_i), .cs2_i(cs2_i), .cs3_n_i(cs3_n_i),
      .pstb_n_i(pstb_n_i), .cstb_n_i(cstb_n_i), .adv_n_i(adv_n_i),
      .bw_n_i(bw_n_i), .bwen_n_i(bwen_n_i), .gw_n_i(gw_n_i),
      .order_i(order_i), .oe_n_i(oe_n_i), .q_o(q_o), .q_en_o(q_en_o));

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   typedef struct {
      int            due;
      logic          en;
      logic [DW-1:0] d;
      int            req;
   } exp_t;
   exp_t sb[$];

   // reference model state
   logic [DW-1:0] ref_mem [1 << AW];
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   bit            m_active = 1'b0, m_last_rd = 1'b0;
   logic [DW-1:0] m_q = '0;

   task automatic check(input bit ok, input int req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // one clock of pins; p/c are strobes asserted when 1
   task automatic op(input bit p, input bit c, input bit cs1n, input bit cs2,
                     input bit advn, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input bit gwn, input bit bwenn, input logic [NB-1:0] bwn,
                     input bit ord, input int req);
      bit pl, ld, sel, wr, rd;
      logic [NB-1:0] mask;
      logic [AW-1:0] ea;
      exp_t it;
      @(negedge clk);
      pstb_n_i = ~p; cstb_n_i = ~c; cs1_n_i = cs1n; cs2_i = cs2; cs3_n_i = 1'b0;
      adv_n_i = advn; addr_i = a; wdata_i = wd; gw_n_i = gwn; bwen_n_i = bwenn;
      bw_n_i = bwn; order_i = ord;
      pl  = p & ~cs1n;
      ld  = pl | c;
      sel = ~cs1n & cs2;
      if (ld) begin
         m_base = a; m_cnt = 2'd0; m_active = sel;
      end else if (m_active && !advn) begin
         m_cnt = m_cnt + 2'd1;
      end
      if (!gwn)        mask = '1;
      else if (!bwenn) mask = ~bwn;
      else             mask = '0;
      ea = {m_base[AW-1:2], ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      wr = m_active && !pl && (mask != '0);
      rd = m_active && !wr;
      if (wr) begin
         for (int b = 0; b < NB; b++)
            if (mask[b]) ref_mem[ea][b*8 +: 8] = wd[b*8 +: 8];
      end
      if (rd) m_q = ref_mem[ea];
      it.due = cyc + 2;
      it.en  = rd | (!m_active & m_last_rd);
      it.d   = m_q;
      it.req = req;
      m_last_rd = rd;
      sb.push_back(it);
   endtask

   // scoreboard monitor
   always begin
      @(negedge clk);
      #2;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         exp_t it;
         it = sb.pop_front();
         check(q_en_o === it.en, it.req, "q_en_o", {{(DW-1){1'b0}}, q_en_o}, {{(DW-1){1'b0}}, it.en});
         if (it.en) check(q_o === it.d, it.req, "q_o", q_o, it.d);
      end
   end

   function automatic logic [DW-1:0] pat(input int i);
      return 32'h5A3C0F00 ^ (i * 32'h01030507);
   endfunction

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      check(q_en_o === 1'b0, 1, "q_en_o after reset", {{(DW-1){1'b0}}, q_en_o}, '0); // R1

      // R5: global writes at 8..11 via controller strobe
      for (int i = 8; i < 12; i++) op(0, 1, 0, 1, 1, AW'(i), pat(i), 0, 1, '1, 0, 5);
      // R8 / R6: write burst at 16 using advance, linear order
      op(0, 1, 0, 1, 1, AW'(16), pat(16), 0, 1, '1, 0, 8);
      for (int i = 1; i < 4; i++) op(0, 0, 0, 1, 0, '0, pat(16 + i), 0, 1, '1, 0, 8);

      // R2 / R3 / R6: processor read burst from 17, linear: 17,18,19,16
      op(1, 0, 0, 1, 1, AW'(17), '0, 1, 1, '1, 0, 3);
      for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0, '0, '0, 1, 1, '1, 0, 6);
      // R7: interleaved from 17: 17,16,19,18
      op(1, 0, 0, 1, 1, AW'(17), '0, 1, 1, '1, 1, 2);
      for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0, '0, '0, 1, 1, '1, 1, 7);

      // R3: processor strobe with global write asserted still reads
      op(1, 0, 0, 1, 1, AW'(10), 32'hDEADBEEF, 0, 0, '0, 0, 3);
      // R4: processor strobe with cs1 high is ignored, address repeats
      op(1, 0, 1, 1, 1, AW'(12), '0, 1, 1, '1, 0, 4);
      // R8: suspend repeats address
      op(0, 0, 0, 1, 1, '0, '0, 1, 1, '1, 0, 8);
      // R3: both strobes, processor wins: read of 11 despite write
      op(1, 1, 0, 1, 1, AW'(11), 32'h11111111, 0, 1, '1, 0, 3);
      op(1, 0, 0, 1, 1, AW'(11), '0, 1, 1, '1, 0, 3);

      // R11: byte write of lanes 0 and 2 at 8, then read back
      op(0, 1, 0, 1, 1, AW'(8), 32'hC3C3C3C3, 1, 0, 4'b1010, 0, 11);
      op(1, 0, 0, 1, 1, AW'(8), '0, 1, 1, '1, 0, 11);
      // R11: no write qualifier: controller load of 9 is a read
      op(0, 1, 0, 1, 1, AW'(9), 32'h77777777, 1, 1, 4'b0000, 0, 11);
      // R5: global write overrides disabled byte enables at 10
      op(0, 1, 0, 1, 1, AW'(10), 32'h0BADF00D, 0, 1, 4'b1111, 0, 5);
      op(1, 0, 0, 1, 1, AW'(10), '0, 1, 1, '1, 0, 5);

      // R9: deselect after read: one held cycle then off
      op(1, 0, 0, 1, 1, AW'(18), '0, 1, 1, '1, 0, 9);
      op(0, 1, 0, 0, 1, AW'(0), '0, 1, 1, '1, 0, 9);
      op(0, 0, 0, 1, 0, '0, '0, 1, 1, '1, 0, 9);
      op(0, 0, 0, 1, 0, '0, '0, 1, 1, '1, 0, 9);
      drain();

      // R10: output enable while reads keep drivers on
      op(1, 0, 0, 1, 1, AW'(19), '0, 1, 1, '1, 0, 10);
      op(0, 0, 0, 1, 1, '0, '0, 1, 1, '1, 0, 10);
      drain();
      oe_n_i = 1'b1; #1;
      check(q_en_o === 1'b0, 10, "q_en_o with oe high", {{(DW-1){1'b0}}, q_en_o}, '0);
      oe_n_i = 1'b0; #1;
      check(q_en_o === 1'b1, 10, "q_en_o with oe low", {{(DW-1){1'b0}}, q_en_o}, 1);
      check(q_o === ref_mem[19], 10, "q_o with oe low", q_o, ref_mem[19]);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule